// File: doc/BRIEF.md
# Status Silo Byte Readout Queue

This block holds a small queue of 16-bit status words that a 12-bit host reads out eight bits at a time. It also keeps the completion (done) flag, the accumulated error bits with their summary flag, and the interrupt request. The host tests done and error with skip strobes, and each test clears the flag it looks at. The queue has two load sources. A drive-status load copies one word into every entry. A header load builds a word from cylinder, head and sector into the head entry and zeroes the others.

Each byte read returns the low half of the head entry or its high half, alternating between the two. Reading a high half moves the queue forward by one entry. The last entry keeps its value. Loading a new command word puts the side pointer back on the low half and clears every flag. Completion of an operation ORs its error bits into the error register and raises the interrupt only when interrupt enable was set in the last command word.

Top module: `status_silo`

## Requirements
- R1: With the side pointer on the low half (the state after reset or a command load), a byte read returns bits 7:0 of the head entry on `rd_data` one clock after the strobe.
- R2: With the side pointer on the high half, a byte read returns bits 15:8 of the head entry. The queue then moves forward: entry 1 goes to the head and entry 2 goes to entry 1. Entry 2 keeps its value.
- R3: The side pointer toggles after every byte read. A command load (`cmd_load`) returns it to the low half.
- R4: A drive-status load writes `gsta_word` into all three entries.
- R5: A header load writes ((cyl*2 + head) << 6) | sector into the head entry and zero into entries 1 and 2.
- R6: A done test pulses `skip_done` one clock later if done was set. It clears done and `irq`.
- R7: An error test pulses `skip_err` one clock later if the error flag was set. It clears only the error flag.
- R8: `done_set` sets done and ORs `done_status` into the error register. The error flag is set when the register is nonzero afterwards, so bits from earlier completions count. `irq` is raised only if `ctl_ie` (bit 8 of the command word) was 1 at the last command load. Otherwise `irq` is held low.
- R9: A command load clears done, the error register, the error flag and `irq`, and latches `ctl_ie`.
- R10: A reset clears all entries, the side pointer, `rd_data` and all flags within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Command word B load strobe |
| ctl_ie | input | 1 | Interrupt-enable bit (bit 8) of the command word being loaded |
| gsta_load | input | 1 | Drive-status load strobe |
| gsta_word | input | 16 | Drive-status word |
| hdr_load | input | 1 | Header load strobe |
| hdr_cyl | input | 9 | Current cylinder |
| hdr_head | input | 1 | Current head |
| hdr_sector | input | 6 | Current sector |
| rd_strobe | input | 1 | Byte read strobe |
| done_set | input | 1 | Operation completion strobe |
| done_status | input | 12 | Error bits reported with completion |
| skip_done_test | input | 1 | Skip-if-done test strobe |
| skip_err_test | input | 1 | Skip-if-error test strobe |
| rd_data | output | 8 | Byte returned by the last read |
| skip_done | output | 1 | Skip indication of the done test |
| skip_err | output | 1 | Skip indication of the error test |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that at most one strobe is active in any cycle. The block gives loads priority over reads and command loads priority over completion and tests, and the properties are written for the single-strobe case only. The bench drives each strobe for exactly one clock from its own task and never overlaps them. Because of this, every check sees the effect of one event alone.

// File: rtl/silo_pkg.sv
package silo_pkg;
  typedef enum logic {
    SIDE_LO = 1'b0,
    SIDE_HI = 1'b1
  } side_e;
endpackage

// File: rtl/silo_queue.sv
module silo_queue
  import silo_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 3,
  parameter int CYL_W  = 9,
  parameter int SEC_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_load,
  input  logic              gsta_load,
  input  logic [2*BYTE_W-1:0] gsta_word,
  input  logic              hdr_load,
  input  logic [CYL_W-1:0]  hdr_cyl,
  input  logic              hdr_head,
  input  logic [SEC_W-1:0]  hdr_sector,
  input  logic              rd_strobe,
  output logic [BYTE_W-1:0] rd_data,
  output logic              side_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int HDR_W  = CYL_W + 1 + SEC_W;

  logic [WORD_W-1:0] ent [DEPTH];
  side_e             side_q;
  logic [HDR_W-1:0]  hdr_raw;
  logic [WORD_W-1:0] hdr_word;
  logic              any_load;
  logic              advance;

  // Track number is cylinder*2 + head; the sector sits below it.
  assign hdr_raw  = {hdr_cyl, hdr_head, hdr_sector};
  assign hdr_word = WORD_W'(hdr_raw);
  assign any_load = gsta_load | hdr_load;
  assign advance  = rd_strobe & ~any_load & (side_q == SIDE_HI);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [WORD_W-1:0] next_up;
    if (g < DEPTH - 1) begin : g_mid
      assign next_up = ent[g+1];
    end else begin : g_last
      assign next_up = ent[g];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        ent[g] <= '0;
      end else if (gsta_load) begin
        ent[g] <= gsta_word;
      end else if (hdr_load) begin
        ent[g] <= (g == 0) ? hdr_word : '0;
      end else if (advance) begin
        ent[g] <= next_up;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q <= SIDE_LO;
    end else if (cmd_load) begin
      side_q <= SIDE_LO;
    end else if (rd_strobe && !any_load) begin
      side_q <= (side_q == SIDE_LO) ? SIDE_HI : SIDE_LO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_strobe && !any_load) begin
      rd_data <= (side_q == SIDE_HI) ? ent[0][WORD_W-1:BYTE_W] : ent[0][BYTE_W-1:0];
    end
  end

  assign side_o = (side_q == SIDE_HI);
endmodule

// File: rtl/silo_flags.sv
module silo_flags #(
  parameter int ERR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_load,
  input  logic             ctl_ie,
  input  logic             done_set,
  input  logic [ERR_W-1:0] done_status,
  input  logic             skip_done_test,
  input  logic             skip_err_test,
  output logic             done_o,
  output logic             err_flag_o,
  output logic             irq_o,
  output logic             skip_done_o,
  output logic             skip_err_o
);
  logic [ERR_W-1:0] err_reg;
  logic [ERR_W-1:0] err_next;
  logic             ie_q;

  assign err_next = err_reg | done_status;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_reg     <= '0;
      ie_q        <= 1'b0;
      done_o      <= 1'b0;
      err_flag_o  <= 1'b0;
      irq_o       <= 1'b0;
      skip_done_o <= 1'b0;
      skip_err_o  <= 1'b0;
    end else begin
      skip_done_o <= 1'b0;
      skip_err_o  <= 1'b0;
      if (cmd_load) begin
        ie_q       <= ctl_ie;
        err_reg    <= '0;
        done_o     <= 1'b0;
        err_flag_o <= 1'b0;
        irq_o      <= 1'b0;
      end else if (done_set) begin
        done_o     <= 1'b1;
        err_reg    <= err_next;
        err_flag_o <= err_flag_o | (|err_next);
        irq_o      <= ie_q;
      end else begin
        if (skip_done_test) begin
          skip_done_o <= done_o;
          done_o      <= 1'b0;
          irq_o       <= 1'b0;
        end
        if (skip_err_test) begin
          skip_err_o <= err_flag_o;
          err_flag_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/status_silo.sv
module status_silo #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 3,
  parameter int CYL_W  = 9,
  parameter int SEC_W  = 6,
  parameter int ERR_W  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_load,
  input  logic                ctl_ie,
  input  logic                gsta_load,
  input  logic [2*BYTE_W-1:0] gsta_word,
  input  logic                hdr_load,
  input  logic [CYL_W-1:0]    hdr_cyl,
  input  logic                hdr_head,
  input  logic [SEC_W-1:0]    hdr_sector,
  input  logic                rd_strobe,
  input  logic                done_set,
  input  logic [ERR_W-1:0]    done_status,
  input  logic                skip_done_test,
  input  logic                skip_err_test,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                skip_done,
  output logic                skip_err,
  output logic                irq
);
  logic side_q;
  logic done_q;
  logic err_flag_q;

  silo_queue #(
    .BYTE_W(BYTE_W), .DEPTH(DEPTH), .CYL_W(CYL_W), .SEC_W(SEC_W)
  ) u_queue (
    .clk(clk), .rst(rst), .cmd_load(cmd_load),
    .gsta_load(gsta_load), .gsta_word(gsta_word),
    .hdr_load(hdr_load), .hdr_cyl(hdr_cyl), .hdr_head(hdr_head),
    .hdr_sector(hdr_sector), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .side_o(side_q)
  );

  silo_flags #(.ERR_W(ERR_W)) u_flags (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .ctl_ie(ctl_ie),
    .done_set(done_set), .done_status(done_status),
    .skip_done_test(skip_done_test), .skip_err_test(skip_err_test),
    .done_o(done_q), .err_flag_o(err_flag_q), .irq_o(irq),
    .skip_done_o(skip_done), .skip_err_o(skip_err)
  );
endmodule

// File: rtl/status_silo_chk.sv
module status_silo_chk (
  input logic clk,
  input logic rst,
  input logic cmd_load,
  input logic gsta_load,
  input logic hdr_load,
  input logic rd_strobe,
  input logic done_set,
  input logic skip_done_test,
  input logic skip_err_test,
  input logic side_q,
  input logic done_q,
  input logic err_flag_q,
  input logic irq,
  input logic skip_done,
  input logic skip_err
);
  logic quiet_other;
  assign quiet_other = !cmd_load && !gsta_load && !hdr_load;

  p_side_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && quiet_other) |=> (side_q != $past(side_q)));

  p_cmd_clears_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_load |=> (!done_q && !err_flag_q && !irq && !side_q));

  p_done_test_r6: assert property (@(posedge clk) disable iff (rst)
    (skip_done_test && !cmd_load && !done_set) |=>
      (skip_done == $past(done_q) && !done_q && !irq));

  p_err_test_r7: assert property (@(posedge clk) disable iff (rst)
    (skip_err_test && !cmd_load && !done_set) |=>
      (skip_err == $past(err_flag_q) && !err_flag_q));

  p_irq_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_q);

  p_done_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (done_set && !cmd_load) |=> done_q);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!done_q && !err_flag_q && !irq && !side_q && !skip_done && !skip_err));
endmodule

bind status_silo status_silo_chk u_chk (
  .clk(clk), .rst(rst), .cmd_load(cmd_load), .gsta_load(gsta_load),
  .hdr_load(hdr_load), .rd_strobe(rd_strobe), .done_set(done_set),
  .skip_done_test(skip_done_test), .skip_err_test(skip_err_test),
  .side_q(side_q), .done_q(done_q), .err_flag_q(err_flag_q), .irq(irq),
  .skip_done(skip_done), .skip_err(skip_err)
);

// File: tb/status_silo_bench.sv
module status_silo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_load = 0, ctl_ie = 0, gsta_load = 0, hdr_load = 0;
  logic [15:0] gsta_word = '0;
  logic [8:0]  hdr_cyl = '0;
  logic        hdr_head = 0;
  logic [5:0]  hdr_sector = '0;
  logic        rd_strobe = 0, done_set = 0;
  logic [11:0] done_status = '0;
  logic        skip_done_test = 0, skip_err_test = 0;
  logic [7:0]  rd_data;
  logic        skip_done, skip_err, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  status_silo u_status_silo (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_byte(output logic [7:0] b);
    rd_strobe = 1; @(negedge clk); rd_strobe = 0; b = rd_data;
  endtask

  task automatic do_cmd(input logic ie);
    ctl_ie = ie; cmd_load = 1; @(negedge clk); cmd_load = 0;
  endtask

  task automatic do_done(input logic [11:0] st);
    done_status = st; done_set = 1; @(negedge clk); done_set = 0;
  endtask

  task automatic test_done(output logic s);
    skip_done_test = 1; @(negedge clk); skip_done_test = 0; s = skip_done;
  endtask

  task automatic test_err(output logic s);
    skip_err_test = 1; @(negedge clk); skip_err_test = 0; s = skip_err;
  endtask

  task automatic t_reset();
    logic s;
    check("R10 rd_data", {8'h0, rd_data}, 16'h0);
    check("R10 irq", {15'h0, irq}, 16'h0);
    test_done(s); check("R10 done clear", {15'h0, s}, 16'h0);
    test_err(s);  check("R10 err clear", {15'h0, s}, 16'h0);
  endtask

  task automatic t_status_fill();
    logic [7:0] b;
    do_cmd(0);
    gsta_word = 16'hA5C3; gsta_load = 1; @(negedge clk); gsta_load = 0;
    for (int i = 0; i < 4; i++) begin
      read_byte(b); check("R1 R4 low byte", {8'h0, b}, 16'h00C3);
      read_byte(b); check("R2 R4 high byte", {8'h0, b}, 16'h00A5);
    end
  endtask

  task automatic t_header();
    logic [7:0] b;
    logic [15:0] w;
    do_cmd(0);
    hdr_cyl = 9'h12D; hdr_head = 1; hdr_sector = 6'h1B;
    w = 16'((({7'h0, hdr_cyl} * 16'd2) + {15'h0, hdr_head}) * 16'd64) | {10'h0, hdr_sector};
    hdr_load = 1; @(negedge clk); hdr_load = 0;
    read_byte(b); check("R5 R1 header low", {8'h0, b}, {8'h0, w[7:0]});
    read_byte(b); check("R5 R2 header high", {8'h0, b}, {8'h0, w[15:8]});
    read_byte(b); check("R5 R2 ripple entry1 low", {8'h0, b}, 16'h0);
    read_byte(b); check("R5 R2 ripple entry1 high", {8'h0, b}, 16'h0);
  endtask

  task automatic t_side_reset();
    logic [7:0] b;
    gsta_word = 16'h1234; gsta_load = 1; @(negedge clk); gsta_load = 0;
    read_byte(b); check("R3 first low", {8'h0, b}, 16'h0034);
    do_cmd(0);
    read_byte(b); check("R3 low again after cmd", {8'h0, b}, 16'h0034);
    read_byte(b); check("R3 toggled to high", {8'h0, b}, 16'h0012);
  endtask

  task automatic t_flags();
    logic s;
    do_cmd(1);
    do_done(12'h0);
    check("R8 irq with ie", {15'h0, irq}, 16'h1);
    test_err(s);  check("R8 no error flag", {15'h0, s}, 16'h0);
    test_done(s); check("R6 skip on done", {15'h0, s}, 16'h1);
    check("R6 irq cleared", {15'h0, irq}, 16'h0);
    test_done(s); check("R6 done cleared", {15'h0, s}, 16'h0);
    do_cmd(0);
    do_done(12'h400);
    check("R8 no irq without ie", {15'h0, irq}, 16'h0);
    test_err(s); check("R7 skip on error", {15'h0, s}, 16'h1);
    test_err(s); check("R7 error flag cleared", {15'h0, s}, 16'h0);
    test_done(s); check("R7 done untouched", {15'h0, s}, 16'h1);
    do_done(12'h0);
    test_err(s); check("R8 accumulated error", {15'h0, s}, 16'h1);
    do_cmd(1);
    test_err(s);  check("R9 error cleared", {15'h0, s}, 16'h0);
    test_done(s); check("R9 done cleared", {15'h0, s}, 16'h0);
    do_done(12'h0);
    test_err(s); check("R9 error register cleared", {15'h0, s}, 16'h0);
    check("R9 ie latched", {15'h0, irq}, 16'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_status_fill();
    t_header();
    t_side_reset();
    t_flags();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule